// File: doc/BRIEF.md
# ARINC 429 Word Serializer

This block takes one 32-bit word at a time over a valid/ready handshake and plays it out as a three-level return-to-zero waveform on two logic-level outputs. `bus_a` high is a One, `bus_b` high is a Zero, and both low is Null. Each bit is a Mark half, which carries the data level, followed by a Space half, which is Null. After the 32nd bit the block holds Null for a fixed inter-word gap. Only then does it raise `word_ready` again.

Timing counts only cycles in which `tick` is high. `tick` is meant to be a 1 MHz enable. A speed select chooses a 5/5 split with a 40-tick gap, or a 40/40 split with a 320-tick gap. The speed select and the parity option are captured when a word is accepted.

With parity enabled, the last bit sent is an odd-parity bit over the first 31 bits, and bit 31 of the loaded word is discarded. A self-test input silences the bus pair. The same three-level stream then appears on a true loopback pair and on a complemented loopback pair, in which One and Zero are swapped.

Top module: `arinc_word_serializer`

## Requirements
- R1: While `rst_n` is low and right after reset, `word_ready` is 1 and all six line outputs are 0.
- R2: A One drives `bus_a`=1, `bus_b`=0. A Zero drives `bus_a`=0, `bus_b`=1. Null drives both to 0. `bus_a` and `bus_b` are never 1 together.
- R3: Bits leave least significant first: `word_data[0]` is the first bit on the line and bit index 31 is the last of the 32.
- R4: With `rate_slow`=0, each bit is 5 ticks of Mark followed by 5 ticks of Null, and the gap after bit 32 is 40 ticks of Null.
- R5: With `rate_slow`=1, each bit is 40 ticks of Mark followed by 40 ticks of Null, and the gap is 320 ticks of Null.
- R6: `word_ready` drops in the cycle after a word is accepted. It stays 0 for 32 bit periods plus the gap, and a `word_valid` offered during that time is ignored. With `tick` high every cycle, `word_ready` returns exactly 360 (fast) or 2880 (slow) cycles after acceptance.
- R7: With `parity_on`=1, the 32nd bit sent is 1 when bits 0..30 hold an even number of ones and 0 otherwise. Input bit 31 has no effect.
- R8: With `parity_on`=0, input bit 31 is sent unchanged as the 32nd bit.
- R9: With `self_test`=1, `bus_a`/`bus_b` stay 0. `lb_true_a`/`lb_true_b` carry the stream with the R2 encoding, and `lb_inv_a`/`lb_inv_b` carry it with One and Zero swapped. With `self_test`=0, all four loopback outputs are 0.
- R10: Changing `rate_slow` or `parity_on` while a word is in flight does not alter that word's timing or bits.
- R11: State advances only in cycles where `tick` is 1. A word consumes exactly 360 tick cycles at fast speed, regardless of how ticks are spaced.
- R12: The Mark half of bit 0 is on the outputs in the first cycle after the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timing enable, one pulse per base-clock period |
| rate_slow | input | 1 | 0 = fast split (5/5/40), 1 = slow split (40/40/320) |
| parity_on | input | 1 | 1 = replace bit 32 with odd parity |
| self_test | input | 1 | 1 = mute bus, drive loopback pairs |
| word_valid | input | 1 | A word is offered |
| word_data | input | 32 | Offered word, bit 0 sent first |
| word_ready | output | 1 | Block idle, will take a word |
| bus_a | output | 1 | Bus One level |
| bus_b | output | 1 | Bus Zero level |
| lb_true_a | output | 1 | Loopback One, unchanged |
| lb_true_b | output | 1 | Loopback Zero, unchanged |
| lb_inv_a | output | 1 | Loopback One of the complemented stream |
| lb_inv_b | output | 1 | Loopback Zero of the complemented stream |

## Verification
Two functions can fall in the same cycle. A new word can be offered while the previous one is still being timed out, up to the last gap ticks. The bench provokes this by holding `word_valid` high with unrelated data through a whole word. It judges the result by `word_ready` staying low and by the cycle-by-cycle waveform matching the first word alone. In the same way, a speed and parity flip arriving in mid-word is judged against the waveform computed from the settings at acceptance.

// File: rtl/arinc_ser_pkg.sv
package arinc_ser_pkg;

  localparam int WORD_BITS = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MARK  = 2'd1,
    ST_SPACE = 2'd2,
    ST_GAP   = 2'd3
  } stage_t;

  // Odd-parity fill bit: makes the 32-bit total count of ones odd.
  function automatic logic odd_fill(input logic [WORD_BITS-2:0] body);
    return ~(^body);
  endfunction

  // Word as it will be shifted out, with optional parity substitution.
  function automatic logic [WORD_BITS-1:0] seal_word(input logic [WORD_BITS-1:0] w,
                                                     input logic par);
    logic [WORD_BITS-1:0] r;
    r = w;
    if (par) r[WORD_BITS-1] = odd_fill(w[WORD_BITS-2:0]);
    return r;
  endfunction

  // Length selector for the two speed settings.
  function automatic int unsigned pick_len(input logic slow,
                                           input int unsigned fast_len,
                                           input int unsigned slow_len);
    return slow ? slow_len : fast_len;
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/arinc_ser_timer.sv
module arinc_ser_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);

  logic [CNT_W-1:0] cnt;

  assign expire = tick && !clear && (cnt == (limit - CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (tick) begin
      if (expire) cnt <= '0;
      else        cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/arinc_ser_shreg.sv
module arinc_ser_shreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         advance,
  output logic         cur_bit,
  output logic         final_bit
);

  localparam int IDX_W = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]     sh;
  logic [IDX_W-1:0] idx;

  assign cur_bit   = sh[0];
  assign final_bit = (idx == IDX_W'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      idx <= '0;
    end else if (load) begin
      sh  <= din;
      idx <= '0;
    end else if (advance) begin
      sh  <= sh >> 1;
      idx <= idx + IDX_W'(1);
    end
  end

endmodule

// File: rtl/arinc_ser_linecode.sv
module arinc_ser_linecode (
  input  logic mark_phase,
  input  logic bit_val,
  input  logic self_test,
  output logic bus_a,
  output logic bus_b,
  output logic lb_true_a,
  output logic lb_true_b,
  output logic lb_inv_a,
  output logic lb_inv_b
);

  logic sym_one;
  logic sym_zero;

  assign sym_one  = mark_phase &&  bit_val;
  assign sym_zero = mark_phase && !bit_val;

  assign bus_a     = sym_one  && !self_test;
  assign bus_b     = sym_zero && !self_test;
  assign lb_true_a = sym_one  &&  self_test;
  assign lb_true_b = sym_zero &&  self_test;
  assign lb_inv_a  = sym_zero &&  self_test;
  assign lb_inv_b  = sym_one  &&  self_test;

endmodule

// File: rtl/arinc_word_serializer.sv
module arinc_word_serializer
  import arinc_ser_pkg::*;
#(
  parameter int unsigned HI_HALF = 5,
  parameter int unsigned LO_HALF = 40,
  parameter int unsigned HI_GAP  = 40,
  parameter int unsigned LO_GAP  = 320
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rate_slow,
  input  logic                 parity_on,
  input  logic                 self_test,
  input  logic                 word_valid,
  input  logic [WORD_BITS-1:0] word_data,
  output logic                 word_ready,
  output logic                 bus_a,
  output logic                 bus_b,
  output logic                 lb_true_a,
  output logic                 lb_true_b,
  output logic                 lb_inv_a,
  output logic                 lb_inv_b
);

  localparam int unsigned MAX_LEN = max_of(max_of(HI_HALF, LO_HALF), max_of(HI_GAP, LO_GAP));
  localparam int          CNT_W   = $clog2(MAX_LEN + 1);

  stage_t           stage;
  logic             slow_q;
  logic [CNT_W-1:0] span;

  // Named internal events.
  logic word_accept;
  logic phase_end;
  logic mark_end;
  logic bit_done;
  logic word_done;
  logic gap_done;
  logic cur_bit;
  logic final_bit;

  assign word_ready  = (stage == ST_IDLE);
  assign word_accept = word_valid && word_ready;
  assign mark_end    = phase_end && (stage == ST_MARK);
  assign bit_done    = phase_end && (stage == ST_SPACE) && !final_bit;
  assign word_done   = phase_end && (stage == ST_SPACE) &&  final_bit;
  assign gap_done    = phase_end && (stage == ST_GAP);

  always_comb begin
    if (stage == ST_GAP) span = CNT_W'(pick_len(slow_q, HI_GAP, LO_GAP));
    else                 span = CNT_W'(pick_len(slow_q, HI_HALF, LO_HALF));
  end

  arinc_ser_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .clear  (word_accept),
    .limit  (span),
    .expire (phase_end)
  );

  arinc_ser_shreg #(.W(WORD_BITS)) u_shreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (word_accept),
    .din       (seal_word(word_data, parity_on)),
    .advance   (bit_done),
    .cur_bit   (cur_bit),
    .final_bit (final_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage  <= ST_IDLE;
      slow_q <= 1'b0;
    end else begin
      unique case (stage)
        ST_IDLE: if (word_accept) begin
          stage  <= ST_MARK;
          slow_q <= rate_slow;
        end
        ST_MARK:  if (mark_end)  stage <= ST_SPACE;
        ST_SPACE: begin
          if (word_done)     stage <= ST_GAP;
          else if (bit_done) stage <= ST_MARK;
        end
        ST_GAP:   if (gap_done)  stage <= ST_IDLE;
        default:  stage <= ST_IDLE;
      endcase
    end
  end

  arinc_ser_linecode u_line (
    .mark_phase (stage == ST_MARK),
    .bit_val    (cur_bit),
    .self_test  (self_test),
    .bus_a      (bus_a),
    .bus_b      (bus_b),
    .lb_true_a  (lb_true_a),
    .lb_true_b  (lb_true_b),
    .lb_inv_a   (lb_inv_a),
    .lb_inv_b   (lb_inv_b)
  );

endmodule

// File: rtl/arinc_ser_chk.sv
module arinc_ser_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic self_test,
  input logic word_valid,
  input logic word_ready,
  input logic word_accept,
  input logic bus_a,
  input logic bus_b,
  input logic lb_true_a,
  input logic lb_true_b,
  input logic lb_inv_a,
  input logic lb_inv_b
);

  logic out_any;
  assign out_any = bus_a || bus_b || lb_true_a || lb_true_b;

  // R2
  excl_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_a && bus_b));

  // R9
  mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    self_test |-> (!bus_a && !bus_b));

  // R9
  loop_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_inv_a == lb_true_b) && (lb_inv_b == lb_true_a));

  // R9
  loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !self_test |-> (!lb_true_a && !lb_true_b && !lb_inv_a && !lb_inv_b));

  // R6
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready) |=> !word_ready);

  // R1
  idle_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> !out_any);

  // R11
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !word_accept) |=> ($stable(word_ready) && $stable(out_any)));

endmodule

bind arinc_word_serializer arinc_ser_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .self_test   (self_test),
  .word_valid  (word_valid),
  .word_ready  (word_ready),
  .word_accept (word_accept),
  .bus_a       (bus_a),
  .bus_b       (bus_b),
  .lb_true_a   (lb_true_a),
  .lb_true_b   (lb_true_b),
  .lb_inv_a    (lb_inv_a),
  .lb_inv_b    (lb_inv_b)
);

// File: tb/arinc_word_serializer_bench.sv
module arinc_word_serializer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        rate_slow = 1'b0;
  logic        parity_on = 1'b0;
  logic        self_test = 1'b0;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic        word_ready, bus_a, bus_b, lb_true_a, lb_true_b, lb_inv_a, lb_inv_b;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  arinc_word_serializer u_arinc_word_serializer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rate_slow(rate_slow),
    .parity_on(parity_on), .self_test(self_test), .word_valid(word_valid),
    .word_data(word_data), .word_ready(word_ready), .bus_a(bus_a), .bus_b(bus_b),
    .lb_true_a(lb_true_a), .lb_true_b(lb_true_b), .lb_inv_a(lb_inv_a), .lb_inv_b(lb_inv_b)
  );

  // Vector: [35:4] data, [3] slow, [2] parity, [1] self-test, [0] offer junk while busy
  localparam int NV = 7;
  localparam logic [35:0] VEC [NV] = '{
    {32'hA5A5_0F0F, 4'b0100},
    {32'h0000_0000, 4'b0100},
    {32'hFFFF_FFFF, 4'b0000},
    {32'h8000_0001, 4'b0101},
    {32'h1234_5678, 4'b0011},
    {32'h7FFF_FFFE, 4'b1100},
    {32'h0F0F_F0F0, 4'b1010}
  };

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bench-side bit model: odd parity by counting ones in bits 0..30.
  function automatic logic sent_bit(input logic [31:0] d, input logic par, input int i);
    int ones;
    if (i < 31 || !par) return d[i];
    ones = 0;
    for (int j = 0; j < 31; j++) ones += int'(d[j]);
    return (ones % 2 == 0) ? 1'b1 : 1'b0;
  endfunction

  task automatic run_word(input logic [31:0] d, input logic sl, input logic pa,
                          input logic st, input logic jk, input logic fl, input string req);
    int h, p, g, tot, werr, rerr;
    logic one, zero, b;
    logic [5:0] exp_o, act_o;
    h = sl ? 40 : 5;
    p = 2 * h;
    g = sl ? 320 : 40;
    tot = 32 * p + g;
    werr = 0;
    rerr = 0;
    @(negedge clk);
    rate_slow = sl; parity_on = pa; self_test = st;
    word_valid = 1'b1; word_data = d;
    @(negedge clk);
    word_valid = jk; word_data = ~d;
    for (int k = 0; k < tot; k++) begin
      if (k > 0) @(negedge clk);
      one = 1'b0; zero = 1'b0;
      if (k < 32 * p && (k % p) < h) begin
        b = sent_bit(d, pa, k / p);
        one = b; zero = !b;
      end
      exp_o = st ? {2'b00, one, zero, zero, one} : {one, zero, 4'b0000};
      act_o = {bus_a, bus_b, lb_true_a, lb_true_b, lb_inv_a, lb_inv_b};
      if (act_o !== exp_o) begin
        if (werr == 0) $display("  first mismatch at offset %0d: got %b want %b", k, act_o, exp_o);
        werr++;
      end
      if (word_ready !== 1'b0) rerr++;
      // R12 first Mark right after acceptance
      if (k == 0) chk("R12", "first-cycle outputs", act_o, exp_o);
      // R10 settings flip in mid-word
      if (fl && k == 100) begin rate_slow = ~sl; parity_on = ~pa; end
      if (k == tot - 2) word_valid = 1'b0;
    end
    chk(req, "mismatched waveform cycles", werr, 0);
    chk("R6", "cycles with ready high while busy", rerr, 0);
    @(negedge clk);
    chk("R6", "ready after gap", word_ready, 1'b1);
    rate_slow = 1'b0; parity_on = 1'b0; self_test = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not end actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int tcount;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", word_ready, 1'b1);
    chk("R1", "outputs in reset", {bus_a, bus_b, lb_true_a, lb_true_b, lb_inv_a, lb_inv_b}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", word_ready, 1'b1);

    // Table walk: R2 R3 R4 R5 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      run_word(VEC[i][35:4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], 1'b0,
               "R2 R3 R4 R5 R7 R8 R9");
    end

    // R10 mid-word flip of speed and parity has no effect on the word in flight
    run_word(32'hC3C3_3C3C, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R10");

    // R11 sparse ticks: count ticks consumed by a fast word
    @(negedge clk);
    parity_on = 1'b1; word_valid = 1'b1; word_data = 32'h5555_AAAA; tick = 1'b1;
    @(negedge clk);
    word_valid = 1'b0;
    tick = 1'b0;
    tcount = 0;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      if (tick) tcount++;
      if (word_ready) break;
      tick = ~tick;
    end
    chk("R11", "ticks consumed by one fast word", tcount, 360);
    tick = 1'b1;
    parity_on = 1'b0;

    // R1 reset in mid-word returns to idle Null
    @(negedge clk);
    word_valid = 1'b1; word_data = 32'hFFFF_FFFF;
    @(negedge clk);
    word_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2", "One during mark before reset", {bus_a, bus_b}, 2'b10);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "ready after mid-word reset", word_ready, 1'b1);
    chk("R1", "outputs after mid-word reset", {bus_a, bus_b}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule